// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is a parallel I/O port in which every line can act as an input, an output, or both at once, without any direction register. A CPU-side write strobe loads an output latch. Each latch bit sets the pad controls for its line. A 0 enables a strong pull-down. A 1 leaves only a weak pull-up, so an external open-drain device can still pull the line low. Each write also fires a strong pull-up pulse on every bit written as 1, so that the line rises quickly from 0 to 1.

A CPU-side read strobe samples the resolved pin levels into a read register. A line must hold a 1 in its latch before it can be used as an input. A line whose latch holds 0 always reads back 0, because the strong pull-down dominates. With no external driver attached, a read returns the value last written.

The length of the strong pull-up pulse is given in nanoseconds and converted into clock cycles from the clock period, rounding up. One shared down-counter times the pulse for all bits.

Top module: `qb_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pd_en` is all 0, `spu_en` is all 0 and `rd_data` is all 0. Every latch bit is 1, so a read with no external driver returns all 1s.
- R2: A write (`wr_en`=1 at a rising edge) loads `wr_data` into the latch. From the next cycle, `pd_en` equals the bitwise inverse of the latch, and it stays unchanged until the next write.
- R3: After a write, `spu_en` equals the written value for exactly PULSE_CYC = ceil(PULSE_NS/CLK_NS) cycles, starting the cycle after the write edge. It is then all 0.
- R4: A write during a running pulse restarts the full PULSE_CYC-cycle pulse. The pulse is applied to every bit of the new value that is 1, including bits used as inputs.
- R5: `pd_en` and `spu_en` are never both 1 on the same bit.
- R6: `wpu_en` is all 1 at all times.
- R7: A read (`rd_en`=1 at a rising edge) loads `rd_data` with `pin_in` AND latch, visible on the next cycle. Without a read, `rd_data` holds its value even if the pins change.
- R8: When no external device drives a line, a read returns the latch value of that line.
- R9: When a read and a write happen at the same edge, the read uses the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe: loads the output latch |
| wr_data | input | WIDTH | Value to be written to the latch |
| rd_en | input | 1 | Read strobe: samples the pins |
| pin_in | input | WIDTH | Resolved logic level on each pin |
| rd_data | output | WIDTH | Last value sampled by a read |
| pd_en | output | WIDTH | Strong pull-down enable, one bit per pin |
| spu_en | output | WIDTH | Momentary strong pull-up enable, one bit per pin |
| wpu_en | output | WIDTH | Weak pull-up enable, one bit per pin |

## Verification
The hardest situation to reach is a retrigger: a second write arriving while the first pulse is still running. It has to be shown that the pulse restarts at full length with the new bit pattern, rather than carrying on the old count. The bench writes all 1s, waits about half a pulse, writes a sparse pattern, and then counts the exact number of cycles the new pattern stays on `spu_en`.

Mixed input/output reads are driven through a wired-AND pin model that combines the port's pull-down with an external open-drain source. A read issued at the same edge as a write shows which latch value the sample used.

// File: rtl/qb_port.sv
module qb_port #(
  parameter int WIDTH    = 8,
  parameter int CLK_NS   = 5,
  parameter int PULSE_NS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] spu_en,
  output logic [WIDTH-1:0] wpu_en
);

  localparam int PULSE_CYC = (PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [WIDTH-1:0] latch_q;
  logic [CW-1:0]    pulse_cnt;
  logic             pulse_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '1;
      pulse_cnt <= '0;
      rd_data   <= '0;
    end else begin
      if (wr_en) begin
        latch_q   <= wr_data;
        pulse_cnt <= CW'(PULSE_CYC);
      end else if (pulse_on) begin
        pulse_cnt <= pulse_cnt - CW'(1);
      end
      if (rd_en) rd_data <= pin_in & latch_q;
    end
  end

  assign pulse_on = (pulse_cnt != '0);
  assign pd_en    = ~latch_q;
  assign spu_en   = latch_q & {WIDTH{pulse_on}};
  assign wpu_en   = '1;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pd_en == '0 && spu_en == '0 && rd_data == '0));

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pd_en));

  p_write_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pd_en == ~$past(wr_data));

  p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> spu_en == $past(wr_data));

  p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt == CW'(1) && !wr_en) |=> spu_en == '0);

  p_no_fight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & spu_en) == '0);

  always_comb p_weak_on_r6: assert (wpu_en == '1);

  p_read_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == ($past(pin_in) & ~$past(pd_en)));

  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/qb_port_test.sv
`timescale 1ns/1ps
module qb_port_test;
  localparam int W = 8;
  localparam int PULSE_CYC = 100;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0, ext_lvl = '1;
  logic [W-1:0] pin_in, rd_data, pd_en, spu_en, wpu_en;
  int tests = 0, fails = 0, viol5 = 0, viol6 = 0;

  always #2.5 clk = ~clk;

  assign pin_in = ~pd_en & ext_lvl;

  qb_port #(.WIDTH(W), .CLK_NS(5), .PULSE_NS(500)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .pin_in(pin_in), .rd_data(rd_data),
    .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en));

  always @(negedge clk) if (rst_n) begin
    if ((pd_en & spu_en) != '0) viol5++;
    if (wpu_en != '1) viol6++;
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [W-1:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_len(string req, logic [W-1:0] pat);
    int hi = 0;
    for (int i = 0; i < PULSE_CYC + 5; i++) begin
      if (spu_en == pat && pat != '0) hi++;
      else if (spu_en != '0) hi = -1000;
      @(negedge clk);
    end
    check(req, W'(hi), W'(PULSE_CYC));
  endtask

  task automatic t_reset();
    rst_n = 0; idle(3);
    check("R1 pd_en", pd_en, '0);
    check("R1 spu_en", spu_en, '0);
    check("R1 rd_data", rd_data, '0);
    rst_n = 1; @(negedge clk);
    check("R1 pd_en after", pd_en, '0);
    check("R6 wpu_en", wpu_en, '1);
    ext_lvl = '1; do_read();
    check("R1 latch all ones", rd_data, 8'hFF);
  endtask

  task automatic t_write_hold();
    do_write(8'hA5);
    check("R2 pd_en", pd_en, 8'h5A);
    check("R3 spu_en start", spu_en, 8'hA5);
    pulse_len("R3 pulse width", 8'hA5);
    check("R3 spu_en off", spu_en, '0);
    idle(20);
    check("R2 hold", pd_en, 8'h5A);
    ext_lvl = '1; do_read();
    check("R8 read returns latch", rd_data, 8'hA5);
  endtask

  task automatic t_mixed();
    do_write(8'h0F); idle(PULSE_CYC + 2);
    ext_lvl = 8'hF5; do_read();
    check("R7 mixed read", rd_data, 8'h05);
    ext_lvl = 8'h00; idle(3);
    check("R7 hold without read", rd_data, 8'h05);
    do_read();
    check("R7 ext low", rd_data, 8'h00);
    ext_lvl = '1;
  endtask

  task automatic t_retrigger();
    do_write(8'hFF); idle(50);
    check("R4 first pulse alive", spu_en, 8'hFF);
    do_write(8'h81);
    pulse_len("R4 full restart", 8'h81);
  endtask

  task automatic t_rw_same();
    do_write(8'hFF); idle(PULSE_CYC + 2);
    ext_lvl = '1;
    wr_en = 1; wr_data = 8'h00; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R9 old latch read", rd_data, 8'hFF);
    do_read();
    check("R9 new latch read", rd_data, 8'h00);
  endtask

  task automatic t_reset_mid();
    do_write(8'h3C); idle(10);
    rst_n = 0; @(negedge clk);
    check("R1 reset mid pulse spu", spu_en, '0);
    check("R1 reset mid pulse pd", pd_en, '0);
    rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write_hold();
    t_mixed();
    t_retrigger();
    t_rw_same();
    t_reset_mid();
    check("R5 no fight", W'(viol5), '0);
    check("R6 weak always", W'(viol6), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule